// File: doc/BRIEF.md
# Repeater Port Partition and Jabber Monitor

This block watches a single repeater port and decides when the port must be cut off from the shared medium. It tracks three faults. The first is a run of consecutive collided packets. The second is one collision that lasts too long. The third is a reception that never ends (jabber). When a fault is found it raises a partition flag, which the repeater core uses to stop forwarding the port's input. Repeated traffic is still sent out on the port. The flag drops again once the port carries a long enough packet with no collision in it.

A jabber detection raises a separate inhibit flag, which shuts both data paths of the port until its carrier goes away. All time intervals are counted in pulses of an external bit-time strobe, so the same logic serves a 10 Mb/s port and a 100 Mb/s port. The speed input selects which set of limits and disable bits applies.

A packet is the interval during which receive carrier or transmit activity is high. A packet is collided if the collision input is high in any cycle of that interval.

Top module: `port_isolation_monitor`

## Requirements
- R1: At the end of a collided packet, the consecutive-collision count is incremented. If the new count is at least the limit, `partitioned` rises at the clock edge where the packet end is seen. The limit is 32 at 10M (`spd_100`=0) and 64 at 100M (`spd_100`=1).
- R2: `cfg_cc_hi10`=1 doubles the 10M limit to 64. `cfg_cc_hi100`=1 doubles the 100M limit to 128.
- R3: `partitioned` clears at the end of a collision-free packet if that packet lasted more than RECONN_BT strobes (default 512). A received packet and a transmitted packet both count. A packet of RECONN_BT strobes or fewer does not reconnect the port. A packet that ends while `jab_inhibit` is high does not reconnect the port either.
- R4: A packet that ends without a collision clears the consecutive-collision count. The count saturates at its all-ones value and does not wrap.
- R5: Collision held for more than LONG_COL_BT strobes (default 1024) partitions the port at either speed. `partitioned` rises one clock after the strobe that exceeds the limit.
- R6: After JAB_BT strobes (default 65536) of continuous carrier, `jab_inhibit` rises one clock later. It clears at the first strobe with carrier low, and not earlier.
- R7: At 100M, the rise of `jab_inhibit` also sets `partitioned` at the same edge. At 10M, jabber never partitions the port.
- R8: The partition-disable bit of the selected speed clears `partitioned` at the next edge and blocks every partition trigger. The jabber-disable bit of the selected speed does the same for `jab_inhibit`, including the 100M jabber partition. The disable bits of the other speed have no effect.
- R9: Only cycles with `bit_stb` high advance the interval measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One pulse per bit time |
| carrier | input | 1 | Receive carrier present |
| col | input | 1 | Collision on the port |
| tx_act | input | 1 | Repeater is transmitting on the port |
| spd_100 | input | 1 | 1 selects 100M limits, 0 selects 10M |
| cfg_cc_hi10 | input | 1 | Double the 10M collision limit |
| cfg_cc_hi100 | input | 1 | Double the 100M collision limit |
| cfg_dis_part10 | input | 1 | Disable partition at 10M |
| cfg_dis_part100 | input | 1 | Disable partition at 100M |
| cfg_dis_jab10 | input | 1 | Disable jabber at 10M |
| cfg_dis_jab100 | input | 1 | Disable jabber at 100M |
| partitioned | output | 1 | Input of the port is isolated |
| jab_inhibit | output | 1 | Port paths inhibited by jabber |

## Verification
A 100M reception that runs into jabber sets the partition flag in the same cycle that `jab_inhibit` rises. When carrier then drops, the packet end and the still-high inhibit flag arrive together: the packet is clean and longer than the reconnect window, but it must not reconnect the port. The bench provokes this by holding carrier for one strobe beyond the jabber limit. It checks both flags at that exact edge, then releases carrier and confirms that the port stays partitioned while the inhibit flag clears on the next strobe.

// File: rtl/pim_pkg.sv
package pim_pkg;

  typedef struct packed {
    logic cc_hi;
    logic part_off;
    logic jab_off;
  } speed_cfg_t;

  // Collision limit for the selected speed, doubled when requested.
  function automatic int unsigned cc_limit(input logic hi, input int unsigned base);
    return hi ? (base * 2) : base;
  endfunction

endpackage

// File: rtl/pim_strobe_cnt.sv
module pim_strobe_cnt #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic reached
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != LIM_V)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign reached = (cnt_q == LIM_V);
endmodule

// File: rtl/pim_activity.sv
module pim_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic col,
  output logic pkt_end,
  output logic pkt_collided
);
  logic act_q, seen_q;
  logic seen_d;

  always_comb begin
    seen_d = active ? (seen_q | col) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      act_q  <= active;
      seen_q <= seen_d;
    end
  end

  assign pkt_end      = act_q & ~active;
  assign pkt_collided = seen_q;
endmodule

// File: rtl/pim_cc_track.sv
module pim_cc_track #(
  parameter int unsigned CC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pkt_end,
  input  logic            collided,
  input  logic [CC_W-1:0] limit,
  output logic            hit
);
  logic [CC_W-1:0] cnt_q, cnt_d, bumped;

  always_comb begin
    bumped = (&cnt_q) ? cnt_q : (cnt_q + 1'b1);
    cnt_d  = cnt_q;
    if (pkt_end) begin
      cnt_d = collided ? bumped : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit = pkt_end & collided & (bumped >= limit);
endmodule

// File: rtl/port_isolation_monitor.sv
module port_isolation_monitor #(
  parameter int unsigned CC_LIM10    = 32,
  parameter int unsigned CC_LIM100   = 64,
  parameter int unsigned LONG_COL_BT = 1024,
  parameter int unsigned RECONN_BT   = 512,
  parameter int unsigned JAB_BT      = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic carrier,
  input  logic col,
  input  logic tx_act,
  input  logic spd_100,
  input  logic cfg_cc_hi10,
  input  logic cfg_cc_hi100,
  input  logic cfg_dis_part10,
  input  logic cfg_dis_part100,
  input  logic cfg_dis_jab10,
  input  logic cfg_dis_jab100,
  output logic partitioned,
  output logic jab_inhibit
);
  import pim_pkg::*;

  localparam int unsigned CC_MAX = (CC_LIM10 > CC_LIM100) ? CC_LIM10 : CC_LIM100;
  localparam int unsigned CC_W   = $clog2(2 * CC_MAX + 1);

  speed_cfg_t      cfg;
  logic [CC_W-1:0] limit;
  logic            active;
  logic            pkt_end, pkt_collided;
  logic            cc_hit, lc_hit, len_ok, jab_full;
  logic            jab_set, reconn, part_set;
  logic            part_q, part_d, jab_q, jab_d;

  always_comb begin
    if (spd_100) begin
      cfg.cc_hi    = cfg_cc_hi100;
      cfg.part_off = cfg_dis_part100;
      cfg.jab_off  = cfg_dis_jab100;
      limit        = CC_W'(cc_limit(cfg_cc_hi100, CC_LIM100));
    end else begin
      cfg.cc_hi    = cfg_cc_hi10;
      cfg.part_off = cfg_dis_part10;
      cfg.jab_off  = cfg_dis_jab10;
      limit        = CC_W'(cc_limit(cfg_cc_hi10, CC_LIM10));
    end
  end

  assign active = carrier | tx_act;

  pim_activity u_act (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .col         (col),
    .pkt_end     (pkt_end),
    .pkt_collided(pkt_collided)
  );

  pim_cc_track #(.CC_W(CC_W)) u_cc (
    .clk     (clk),
    .rst_n   (rst_n),
    .pkt_end (pkt_end),
    .collided(pkt_collided),
    .limit   (limit),
    .hit     (cc_hit)
  );

  pim_strobe_cnt #(.LIMIT(LONG_COL_BT + 1)) u_long_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~col),
    .inc    (bit_stb & col),
    .reached(lc_hit)
  );

  pim_strobe_cnt #(.LIMIT(RECONN_BT + 1)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~active),
    .inc    (bit_stb & active),
    .reached(len_ok)
  );

  pim_strobe_cnt #(.LIMIT(JAB_BT)) u_jab (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~carrier),
    .inc    (bit_stb & carrier),
    .reached(jab_full)
  );

  always_comb begin
    jab_set  = ~cfg.jab_off & carrier & jab_full & ~jab_q;
    reconn   = pkt_end & ~pkt_collided & len_ok & ~jab_q;
    part_set = cc_hit | lc_hit | (jab_set & spd_100);

    jab_d = jab_q;
    if (cfg.jab_off) begin
      jab_d = 1'b0;
    end else if (jab_set) begin
      jab_d = 1'b1;
    end else if (bit_stb && !carrier) begin
      jab_d = 1'b0;
    end

    part_d = part_q;
    if (cfg.part_off) begin
      part_d = 1'b0;
    end else if (part_set) begin
      part_d = 1'b1;
    end else if (reconn) begin
      part_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= 1'b0;
      jab_q  <= 1'b0;
    end else begin
      part_q <= part_d;
      jab_q  <= jab_d;
    end
  end

  assign partitioned = part_q;
  assign jab_inhibit = jab_q;
endmodule

// File: rtl/port_isolation_monitor_chk.sv
module port_isolation_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic carrier,
  input logic tx_act,
  input logic spd_100,
  input logic cfg_dis_part10,
  input logic cfg_dis_part100,
  input logic cfg_dis_jab10,
  input logic cfg_dis_jab100,
  input logic partitioned,
  input logic jab_inhibit
);
  logic part_off, jab_off;
  assign part_off = spd_100 ? cfg_dis_part100 : cfg_dis_part10;
  assign jab_off  = spd_100 ? cfg_dis_jab100  : cfg_dis_jab10;

  // R8
  part_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_off |=> !partitioned);

  // R8
  jab_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jab_off |=> !jab_inhibit);

  // R6
  jab_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab_inhibit) |-> $past(carrier));

  // R6
  jab_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jab_inhibit) |-> ($past(bit_stb && !carrier) || $past(jab_off)));

  // R7
  jab_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(jab_inhibit) && $past(spd_100) && !$past(part_off)) |-> partitioned);

  // R3
  reconn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(partitioned) |-> ($past(part_off) || $past(!carrier && !tx_act)));
endmodule

bind port_isolation_monitor port_isolation_monitor_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bit_stb        (bit_stb),
  .carrier        (carrier),
  .tx_act         (tx_act),
  .spd_100        (spd_100),
  .cfg_dis_part10 (cfg_dis_part10),
  .cfg_dis_part100(cfg_dis_part100),
  .cfg_dis_jab10  (cfg_dis_jab10),
  .cfg_dis_jab100 (cfg_dis_jab100),
  .partitioned    (partitioned),
  .jab_inhibit    (jab_inhibit)
);

// File: tb/tb_port_isolation_monitor.sv
module tb_port_isolation_monitor;
  localparam int LCB = 64;
  localparam int RCB = 32;
  localparam int JBB = 256;

  logic clk = 1'b0;
  logic rst_n, bit_stb, carrier, col, tx_act, spd_100;
  logic cfg_cc_hi10, cfg_cc_hi100, cfg_dis_part10, cfg_dis_part100;
  logic cfg_dis_jab10, cfg_dis_jab100;
  logic partitioned, jab_inhibit;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  port_isolation_monitor #(
    .LONG_COL_BT(LCB), .RECONN_BT(RCB), .JAB_BT(JBB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .carrier(carrier), .col(col),
    .tx_act(tx_act), .spd_100(spd_100), .cfg_cc_hi10(cfg_cc_hi10),
    .cfg_cc_hi100(cfg_cc_hi100), .cfg_dis_part10(cfg_dis_part10),
    .cfg_dis_part100(cfg_dis_part100), .cfg_dis_jab10(cfg_dis_jab10),
    .cfg_dis_jab100(cfg_dis_jab100), .partitioned(partitioned),
    .jab_inhibit(jab_inhibit)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_stb = 1'b1; carrier = 1'b0; col = 1'b0; tx_act = 1'b0;
    spd_100 = 1'b0; cfg_cc_hi10 = 1'b0; cfg_cc_hi100 = 1'b0;
    cfg_dis_part10 = 1'b0; cfg_dis_part100 = 1'b0;
    cfg_dis_jab10 = 1'b0; cfg_dis_jab100 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Packet of len strobes; collision in its first two cycles when requested.
  task automatic pkt(input int len, input bit collide, input bit use_tx);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (use_tx) tx_act = 1'b1; else carrier = 1'b1;
      col = collide && (i < 2);
    end
    @(negedge clk);
    carrier = 1'b0; tx_act = 1'b0; col = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic hold_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check(partitioned, 1'b0, "R1 reset partitioned");
    check(jab_inhibit, 1'b0, "R6 reset jab_inhibit");

    // R1 R2 R3 R4: sweep speed and limit doubling
    for (int s = 0; s < 2; s++) begin
      for (int h = 0; h < 2; h++) begin
        int lim;
        do_reset();
        spd_100 = s[0];
        if (s == 1) cfg_cc_hi100 = h[0]; else cfg_cc_hi10 = h[0];
        lim = (s == 1 ? 64 : 32) << h;
        for (int k = 0; k < lim - 1; k++) pkt(3, 1'b1, k[0]);
        check(partitioned, 1'b0, "R1/R2 below limit");
        pkt(3, 1'b1, 1'b0);
        check(partitioned, 1'b1, "R1/R2 at limit");
        pkt(RCB, 1'b0, h[0]);
        check(partitioned, 1'b1, "R3 short clean packet keeps partition");
        pkt(RCB + 1, 1'b0, h[0]);
        check(partitioned, 1'b0, "R3 long clean packet reconnects");
        for (int k = 0; k < lim - 1; k++) pkt(3, 1'b1, 1'b0);
        pkt(5, 1'b0, 1'b1);
        for (int k = 0; k < lim - 1; k++) pkt(3, 1'b1, 1'b0);
        check(partitioned, 1'b0, "R4 clean packet clears count");
      end
    end

    // R4 saturation, R8 disable at 10M
    do_reset();
    cfg_dis_part10 = 1'b1;
    for (int k = 0; k < 260; k++) pkt(2, 1'b1, 1'b0);
    check(partitioned, 1'b0, "R8 disabled partition stays low");
    cfg_dis_part10 = 1'b0;
    pkt(2, 1'b1, 1'b0);
    check(partitioned, 1'b1, "R4 count saturated not wrapped");

    // R8 other-speed disable bit has no effect
    do_reset();
    spd_100 = 1'b1; cfg_dis_part10 = 1'b1; cfg_dis_jab10 = 1'b1;
    for (int k = 0; k < 64; k++) pkt(3, 1'b1, 1'b0);
    check(partitioned, 1'b1, "R8 10M disable ignored at 100M");

    // R5 long collision at both speeds
    for (int s = 0; s < 2; s++) begin
      do_reset();
      spd_100 = s[0];
      carrier = 1'b1; col = 1'b1;
      hold_edges(LCB + 1);
      check(partitioned, 1'b0, "R5 collision at limit+1 strobes");
      hold_edges(1);
      check(partitioned, 1'b1, "R5 long collision partitions");
      carrier = 1'b0; col = 1'b0;
      hold_edges(3);
      check(partitioned, 1'b1, "R5 partition held after collision");
    end

    // R5 disabled
    do_reset();
    cfg_dis_part10 = 1'b1;
    carrier = 1'b1; col = 1'b1;
    hold_edges(LCB + 5);
    check(partitioned, 1'b0, "R8 long collision with partition disabled");
    carrier = 1'b0; col = 1'b0;
    hold_edges(2);

    // R9 strobe on every other cycle
    do_reset();
    carrier = 1'b1; col = 1'b1; bit_stb = 1'b1;
    for (int e = 1; e <= 130; e++) begin
      @(posedge clk);
      @(negedge clk);
      bit_stb = ~bit_stb;
      if (e == 129) check(partitioned, 1'b0, "R9 strobes counted, not cycles");
      if (e == 130) check(partitioned, 1'b1, "R9 partition after strobe count");
    end
    carrier = 1'b0; col = 1'b0; bit_stb = 1'b1;
    hold_edges(2);

    // R6 R7 jabber at 10M
    do_reset();
    carrier = 1'b1;
    hold_edges(JBB);
    check(jab_inhibit, 1'b0, "R6 no jabber at threshold edge");
    hold_edges(1);
    check(jab_inhibit, 1'b1, "R6 jabber raised");
    check(partitioned, 1'b0, "R7 no partition on 10M jabber");
    carrier = 1'b0; bit_stb = 1'b0;
    hold_edges(1);
    check(jab_inhibit, 1'b1, "R6 inhibit held without strobe");
    bit_stb = 1'b1;
    hold_edges(1);
    check(jab_inhibit, 1'b0, "R6 inhibit clears on strobe");

    // R7 R3 jabber at 100M, coincident with packet end
    do_reset();
    spd_100 = 1'b1;
    carrier = 1'b1;
    hold_edges(JBB);
    check(partitioned, 1'b0, "R7 no partition before jabber");
    hold_edges(1);
    check(jab_inhibit, 1'b1, "R6 jabber raised at 100M");
    check(partitioned, 1'b1, "R7 jabber partitions at 100M");
    carrier = 1'b0;
    hold_edges(3);
    check(jab_inhibit, 1'b0, "R6 inhibit released at 100M");
    check(partitioned, 1'b1, "R3 jabbered packet does not reconnect");

    // R8 disabling partition clears the flag
    cfg_dis_part100 = 1'b1;
    hold_edges(1);
    check(partitioned, 1'b0, "R8 disable clears partition");
    cfg_dis_part100 = 1'b0;
    hold_edges(2);
    check(partitioned, 1'b0, "R8 re-enable does not restore partition");

    // R8 jabber disabled at 100M
    do_reset();
    spd_100 = 1'b1; cfg_dis_jab100 = 1'b1;
    carrier = 1'b1;
    hold_edges(JBB + 20);
    check(jab_inhibit, 1'b0, "R8 jabber disabled");
    check(partitioned, 1'b0, "R8 no jabber partition when disabled");
    carrier = 1'b0;
    hold_edges(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule